// File: doc/BRIEF.md
# Edge-Capturing Interrupt Aggregator

This block merges a bank of peripheral interrupt sources into a single request line for a parent interrupt controller. Each source is brought into the local clock domain through a synchronizer. A bus master reads, enables and disables the sources through a small word-addressed register port. That port has an address, a write strobe with write data, and a read strobe with combinational read data.

A build-time parameter picks one of two variants. In the capturing variant, a rising edge on a source sets a sticky pending bit. The pending bit stays set until software writes a one to the matching bit of the acknowledge register. In the live variant, the status register follows the synchronized source levels directly, and no acknowledge register exists.

Each source can be disabled. Disabling uses two write-only registers: writing a one to a bit of the first disables that source, and writing a one to a bit of the second enables it. A read-only register shows which sources are currently disabled. The request line is high whenever an enabled source has its status bit set.

Top module: `irq_fold`

## Requirements
- R1: After reset, every disable bit is 1, every status bit is 0 and `irq_o` is 0.
- R2: In the capturing variant (`LATCHED`=1), a rising edge on `src_i[n]` sets status bit n within `SYNC_DEPTH`+1 clock edges. The bit stays set after the source falls again.
- R3: In the capturing variant, writing to the acknowledge register (offset 0x08) clears each status bit written as 1. Status bits written as 0 keep their value.
- R4: In the capturing variant, if a new rising edge and an acknowledge of the same bit take effect in the same cycle, the bit ends up set.
- R5: Writing to the disable-set register sets each disable bit written as 1 and leaves the others unchanged. Its offset is 0x10 in the capturing variant and 0x08 in the live variant.
- R6: Writing to the disable-clear register clears each disable bit written as 1 and leaves the others unchanged. Its offset is 0x14 in the capturing variant and 0x0C in the live variant.
- R7: Reading the disable-status register returns the disable bits, where 1 means disabled. Its offset is 0x0C in the capturing variant and 0x04 in the live variant. The status register is at 0x00 in both variants.
- R8: `irq_o` is 1 exactly when at least one bit of (status AND NOT disable) is 1.
- R9: In the capturing variant, a disabled source still sets its status bit, and `irq_o` rises once that source is enabled, unless the bit was acknowledged first.
- R10: In the live variant (`LATCHED`=0), status bit n follows the synchronized level of `src_i[n]`, so `irq_o` falls when the source falls. No offset clears status.
- R11: Reads of write-only or unmapped offsets return 0. Writes to read-only or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Asynchronous peripheral interrupt sources |
| bus_addr_i | input | BUS_AW | Register byte offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | BUS_DW | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | BUS_DW | Read data, valid in the same cycle as the read strobe, zero when no read is made |
| irq_o | output | 1 | Combined request line to the parent controller |

## Verification
On every cycle, the checker confirms the following:
- The disable bits follow each set write and each clear write.
- The disable-status read returns the disable state.
- Reads of write-only or unmapped offsets return zero.
- Captured status bits never drop without an acknowledge write.
- No request is raised while all sources are disabled.

Only the directed scenarios can show the rest:
- The synchronizer latency.
- Set-over-acknowledge priority at the exact colliding cycle.
- Latching of a disabled source and its release when enabled.
- Live-level tracking in the second variant.
- The reset values.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;
    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_ACK,
        SEL_DSTAT,
        SEL_DSET,
        SEL_DCLR
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [BUS_AW-1:0] addr, input bit latched);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (latched) begin
            case (addr)
                8'h00: sel = SEL_STAT;
                8'h08: sel = SEL_ACK;
                8'h0C: sel = SEL_DSTAT;
                8'h10: sel = SEL_DSET;
                8'h14: sel = SEL_DCLR;
                default: sel = SEL_NONE;
            endcase
        end else begin
            case (addr)
                8'h00: sel = SEL_STAT;
                8'h04: sel = SEL_DSTAT;
                8'h08: sel = SEL_DSET;
                8'h0C: sel = SEL_DCLR;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction
endpackage

// File: rtl/irq_fold_sync.sv
module irq_fold_sync #(
    parameter int unsigned NSRC       = 32,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] lvl_o,
    output logic [NSRC-1:0] rise_o
);
    typedef struct packed {
        logic [SYNC_DEPTH-1:0][NSRC-1:0] chain;
        logic [NSRC-1:0]                 prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = src_i;
        for (int k = 1; k < SYNC_DEPTH; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        st_d.prev = st_q.chain[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.chain[SYNC_DEPTH-1];
    assign rise_o = st_q.chain[SYNC_DEPTH-1] & ~st_q.prev;
endmodule

// File: rtl/irq_fold_pend.sv
module irq_fold_pend #(
    parameter int unsigned NSRC    = 32,
    parameter bit          LATCHED = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] lvl_i,
    input  logic [NSRC-1:0] rise_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] status_o
);
    generate
        if (LATCHED) begin : g_capture
            typedef struct packed {
                logic [NSRC-1:0] pend;
            } pend_t;

            pend_t pd_d, pd_q;

            always_comb begin
                pd_d      = pd_q;
                // a fresh edge overrides an acknowledge in the same cycle
                pd_d.pend = (pd_q.pend & ~ack_i) | rise_i;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) pd_q <= '0;
                else         pd_q <= pd_d;
            end

            logic [NSRC-1:0] unused_lvl;
            assign unused_lvl = lvl_i;
            assign status_o   = pd_q.pend;
        end else begin : g_live
            logic [2*NSRC+1:0] unused_in;
            assign unused_in = {rise_i, ack_i, clk_i, rst_ni};
            assign status_o  = lvl_i;
        end
    endgenerate
endmodule

// File: rtl/irq_fold_mask.sv
module irq_fold_mask #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] mask_o
);
    typedef struct packed {
        logic [NSRC-1:0] dis;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d     = mk_q;
        mk_d.dis = (mk_q.dis | set_i) & ~clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mk_q <= '{dis: '1};
        else         mk_q <= mk_d;
    end

    assign mask_o = mk_q.dis;
endmodule

// File: rtl/irq_fold.sv
module irq_fold
    import irq_fold_pkg::*;
#(
    parameter int unsigned NSRC       = 32,
    parameter int unsigned SYNC_DEPTH = 2,
    parameter bit          LATCHED    = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    input  logic              bus_re_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned PAD_W = BUS_DW - NSRC;

    reg_sel_e        sel_w;
    logic [NSRC-1:0] wbits_w;
    logic [NSRC-1:0] lvl_w, rise_w, ack_w, dset_w, dclr_w;
    logic [NSRC-1:0] status_w, mask_w;

    assign sel_w   = decode(bus_addr_i, LATCHED);
    assign wbits_w = bus_wdata_i[NSRC-1:0];

    always_comb begin
        ack_w  = '0;
        dset_w = '0;
        dclr_w = '0;
        if (bus_we_i) begin
            case (sel_w)
                SEL_ACK:  ack_w  = wbits_w;
                SEL_DSET: dset_w = wbits_w;
                SEL_DCLR: dclr_w = wbits_w;
                default: ;
            endcase
        end
    end

    irq_fold_sync #(.NSRC(NSRC), .SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .src_i (src_i),
        .lvl_o (lvl_w),
        .rise_o(rise_w)
    );

    irq_fold_pend #(.NSRC(NSRC), .LATCHED(LATCHED)) u_pend (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lvl_i   (lvl_w),
        .rise_i  (rise_w),
        .ack_i   (ack_w),
        .status_o(status_w)
    );

    irq_fold_mask #(.NSRC(NSRC)) u_mask (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (dset_w),
        .clr_i (dclr_w),
        .mask_o(mask_w)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_re_i) begin
            case (sel_w)
                SEL_STAT:  bus_rdata_o = BUS_DW'(status_w);
                SEL_DSTAT: bus_rdata_o = BUS_DW'(mask_w);
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic [BUS_DW-1:0] unused_wdata;
            assign unused_wdata = bus_wdata_i;
        end
    endgenerate

    assign irq_o = |(status_w & ~mask_w);
endmodule

// File: rtl/irq_fold_chk.sv
module irq_fold_chk
    import irq_fold_pkg::*;
#(
    parameter int unsigned NSRC    = 32,
    parameter bit          LATCHED = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [BUS_AW-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [BUS_DW-1:0] bus_wdata_i,
    input logic              bus_re_i,
    input logic [BUS_DW-1:0] bus_rdata_o,
    input logic              irq_o,
    input logic [NSRC-1:0]   status,
    input logic [NSRC-1:0]   mask
);
    reg_sel_e        sel_c;
    logic [NSRC-1:0] wb_c;
    assign sel_c = decode(bus_addr_i, LATCHED);
    assign wb_c  = bus_wdata_i[NSRC-1:0];

    // R5
    dset_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && sel_c == SEL_DSET) |=> ((mask & $past(wb_c)) == $past(wb_c)));

    // R6
    dclr_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && sel_c == SEL_DCLR) |=> ((mask & $past(wb_c)) == '0));

    // R7
    dstat_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && sel_c == SEL_DSTAT) |-> (bus_rdata_o == BUS_DW'(mask)));

    // R11
    quiet_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && (sel_c == SEL_NONE || sel_c == SEL_ACK || sel_c == SEL_DSET
                      || sel_c == SEL_DCLR)) |-> (bus_rdata_o == '0));

    // R8
    all_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&mask) |-> !irq_o);

    generate
        if (LATCHED) begin : g_sticky
            // R2
            sticky_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !(bus_we_i && sel_c == SEL_ACK) |=> ((status & $past(status)) == $past(status)));
        end
    endgenerate
endmodule

bind irq_fold irq_fold_chk #(.NSRC(NSRC), .LATCHED(LATCHED)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_re_i   (bus_re_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .status     (status_w),
    .mask       (mask_w)
);

// File: tb/test_irq_fold.sv
module test_irq_fold;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [7:0]  addr_a = '0, addr_b = '0;
    logic        we_a = 1'b0, we_b = 1'b0, re_a = 1'b0, re_b = 1'b0;
    logic [31:0] wd_a = '0, wd_b = '0;
    logic [31:0] rd_a, rd_b;
    logic        irq_a, irq_b;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_fold #(.LATCHED(1'b1)) i_irq_fold (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src_a), .bus_addr_i(addr_a),
        .bus_we_i(we_a), .bus_wdata_i(wd_a), .bus_re_i(re_a),
        .bus_rdata_o(rd_a), .irq_o(irq_a)
    );

    irq_fold #(.LATCHED(1'b0)) i_irq_fold_lvl (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src_b), .bus_addr_i(addr_b),
        .bus_we_i(we_b), .bus_wdata_i(wd_b), .bus_re_i(re_b),
        .bus_rdata_o(rd_b), .irq_o(irq_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit lvl, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (lvl) begin addr_b = a; wd_b = d; we_b = 1'b1; end
        else     begin addr_a = a; wd_a = d; we_a = 1'b1; end
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
    endtask

    task automatic rd(input bit lvl, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        if (lvl) begin addr_b = a; re_b = 1'b1; end
        else     begin addr_a = a; re_a = 1'b1; end
        #1;
        d = lvl ? rd_b : rd_a;
        re_a = 1'b0;
        re_b = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 8'h00, v); chk("R1 status", v, 32'h0);
        rd(0, 8'h0C, v); chk("R1 disable", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq_a}, 32'h0);
        rd(1, 8'h04, v); chk("R1 level disable", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_capture_masked();
        logic [31:0] v;
        @(negedge clk); src_a[3] = 1'b1;
        settle();
        src_a[3] = 1'b0;
        settle();
        rd(0, 8'h00, v); chk("R2 sticky after fall", v, 32'h8);
        chk("R9 masked no irq", {31'b0, irq_a}, 32'h0);
        wr(0, 8'h14, 32'h8);
        rd(0, 8'h0C, v); chk("R6/R7 enable bit3", v, 32'hFFFF_FFF7);
        chk("R9 irq after enable", {31'b0, irq_a}, 32'h1);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(0, 8'h08, 32'h0);
        rd(0, 8'h00, v); chk("R3 zero ack keeps", v, 32'h8);
        wr(0, 8'h08, 32'h8);
        rd(0, 8'h00, v); chk("R3 ack clears", v, 32'h0);
        chk("R8 irq drops", {31'b0, irq_a}, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk); src_a[3] = 1'b1;
        settle();
        src_a[3] = 1'b0;
        settle();
        // source rises at this edge; the ack lands on the edge that captures it
        src_a[3] = 1'b1;
        @(negedge clk);
        wr(0, 8'h08, 32'h8);
        rd(0, 8'h00, v); chk("R4 set beats ack", v, 32'h8);
        src_a[3] = 1'b0;
        settle();
        wr(0, 8'h08, 32'h8);
        rd(0, 8'h00, v); chk("R3 cleared", v, 32'h0);
    endtask

    task automatic t_mask_ops();
        logic [31:0] v;
        wr(0, 8'h14, 32'hF0);
        rd(0, 8'h0C, v); chk("R6 clear field", v, 32'hFFFF_FF07);
        wr(0, 8'h10, 32'h0);
        rd(0, 8'h0C, v); chk("R5 zero set no effect", v, 32'hFFFF_FF07);
        wr(0, 8'h10, 32'h10);
        rd(0, 8'h0C, v); chk("R5 set bit4", v, 32'hFFFF_FF17);
        wr(0, 8'h14, 32'h0);
        rd(0, 8'h0C, v); chk("R6 zero clear no effect", v, 32'hFFFF_FF17);
    endtask

    task automatic t_irq_combine();
        logic [31:0] v;
        @(negedge clk); src_a[4] = 1'b1; src_a[5] = 1'b1;
        settle();
        rd(0, 8'h00, v); chk("R2 two captures", v, 32'h30);
        chk("R8 enabled bit5 raises irq", {31'b0, irq_a}, 32'h1);
        wr(0, 8'h08, 32'h20);
        chk("R8 only disabled pending", {31'b0, irq_a}, 32'h0);
        src_a[4] = 1'b0; src_a[5] = 1'b0;
        wr(0, 8'h08, 32'h10);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(0, 8'h08, v); chk("R11 ack reads zero", v, 32'h0);
        rd(0, 8'h10, v); chk("R11 dset reads zero", v, 32'h0);
        rd(0, 8'h14, v); chk("R11 dclr reads zero", v, 32'h0);
        rd(0, 8'h04, v); chk("R11 hole reads zero", v, 32'h0);
        wr(0, 8'h0C, 32'h0);
        rd(0, 8'h0C, v); chk("R11 dstat write ignored", v, 32'hFFFF_FF17);
        wr(0, 8'h00, 32'hFFFF_FFFF);
        rd(0, 8'h00, v); chk("R11 status write ignored", v, 32'h0);
        wr(0, 8'h24, 32'hFFFF_FFFF);
        rd(0, 8'h0C, v); chk("R11 hole write ignored", v, 32'hFFFF_FF17);
        rd(1, 8'h10, v); chk("R11 level hole reads zero", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(1, 8'h0C, 32'hFFFF_FFFF);
        @(negedge clk); src_b[5] = 1'b1;
        settle();
        rd(1, 8'h00, v); chk("R10 live status", v, 32'h20);
        chk("R10 irq high", {31'b0, irq_b}, 32'h1);
        wr(1, 8'h08, 32'h20);
        rd(1, 8'h04, v); chk("R5 level set disables", v, 32'h20);
        chk("R8 level masked", {31'b0, irq_b}, 32'h0);
        rd(1, 8'h00, v); chk("R10 no clear via 0x08", v, 32'h20);
        wr(1, 8'h0C, 32'h20);
        chk("R10 irq again", {31'b0, irq_b}, 32'h1);
        src_b[5] = 1'b0;
        settle();
        rd(1, 8'h00, v); chk("R10 status follows fall", v, 32'h0);
        chk("R10 irq drops", {31'b0, irq_b}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture_masked();
        t_ack();
        t_set_wins();
        t_mask_ops();
        t_irq_combine();
        t_unmapped();
        t_level();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule